// File: doc/BRIEF.md
# Dual-Interface Power Mode Arbiter

This block chooses which of two mutually exclusive input interfaces is awake: an analog capture path or a digital link. It then drives one enable line per circuit group so that whatever the chosen mode does not need is switched off. It watches three analog activity flags and one digital clock-detect flag. It also takes three control bits from a register bank: a shutdown request, an override enable and an interface select bit.

Three levels of priority settle the mode. A shutdown request wins over everything. A manual override comes next. Automatic detection comes last. When automatic detection sees both interfaces, the select bit decides between them. When it sees neither, the block parks in a seek state: both datapaths are off, but the detectors stay awake so that activity can be found again. A detection change only takes effect after it has held for a programmable number of cycles, so a flickering detector does not make the power mode toggle.

The chosen mode is held in a register as a small code. That code and the synchronised detect flags are presented as a status word that the register bank can read back.

Top module: `pwr_mode_arbiter`

## Requirements
- R1: While reset is held, and after it is released with all detect flags low and no control bit set, the mode code is 1 (seek), the sync indication is low and the enables hold the seek pattern of R9.
- R2: When the shutdown bit is 1 at a clock edge, the mode code after that edge is 0 (off) and all seven enables are 0, whatever the other inputs are.
- R3: When shutdown is 0 and override is 1 at a clock edge, the mode after that edge is 2 (analog) if select is 0 and 3 (digital) if select is 1, whatever the detect flags are.
- R4: The analog interface counts as detected when any one or more of the three analog activity flags is 1.
- R5: Without shutdown or override, when neither interface is detected, the automatic choice is seek (code 1) and the sync indication is 0.
- R6: Without shutdown or override, when exactly one interface is detected, the automatic choice is that interface: code 2 for analog, code 3 for digital.
- R7: Without shutdown or override, when both interfaces are detected, the automatic choice is code 2 if select is 0 and code 3 if select is 1.
- R8: A new automatic choice is adopted at the edge where it has been computed on `settle` consecutive edges, with `settle` = 0 treated as 1. A choice that lasts for fewer edges leaves the mode unchanged. The detect flags pass through SYNC_STAGES flops before the choice is computed.
- R9: Enable bits: [0] analog datapath, [1] digital datapath, [2] analog activity detect, [3] digital clock detect, [4] sync-on-green detect, [5] output drivers, [6] bandgap reference. Off = 0000000. Seek = 1011100. Analog = 1111001. Digital = 1110110 (written bit 6 down to bit 0).
- R10: The sync indication is 1 exactly when the mode code is 2 or 3.
- R11: Status word: bits [7:5] are synchronised analog flags 2..0, bit [4] is the synchronised digital clock-detect flag, bit [3] is the sync indication and bits [2:0] are the mode code.
- R12: The mode code changes only on a rising clock edge and only takes the values 0, 1, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ana_act | input | 3 | Analog activity flags, asynchronous |
| dig_clk_seen | input | 1 | Digital clock-detect flag, asynchronous |
| shutdown | input | 1 | Shutdown request from the register bank |
| ovr_en | input | 1 | Manual override enable |
| if_sel | input | 1 | Interface select: 0 analog, 1 digital |
| settle | input | CNT_W | Number of consecutive edges a new automatic choice must last |
| mode_code | output | 3 | Registered power mode code |
| pwr_en | output | 7 | Enable lines per circuit group |
| sync_seen | output | 1 | An interface is active |
| status | output | 8 | Read-back status word |

## Verification
Each analog flag is raised on its own and then in pairs, to show that any single flag counts as detection. The digital flag is raised alone and together with the analog flags under both select values, which separates the single-detect case from the tie-break. Short pulses shorter than the settle count, followed by held levels, separate a filtered detection path from a direct one, and a settle value of zero is tried as well. Override and shutdown are applied over random detect activity to expose any leak of the priority order, and a long random run with a settle of three compares every output against the reference model on every cycle.

// File: rtl/pma_pkg.sv
// Package: shared mode encoding and enable bit positions for the power
// mode arbiter. Assumes a 3-bit mode code with four legal values.
package pma_pkg;
    typedef enum logic [2:0] {
        MODE_OFF  = 3'd0,
        MODE_SEEK = 3'd1,
        MODE_ANA  = 3'd2,
        MODE_DIG  = 3'd3
    } pmode_e;

    localparam int EN_W       = 7;
    localparam int EN_ANA_DP  = 0;
    localparam int EN_DIG_DP  = 1;
    localparam int EN_ANA_ACT = 2;
    localparam int EN_DIG_CLK = 3;
    localparam int EN_SOG     = 4;
    localparam int EN_OUTDRV  = 5;
    localparam int EN_BGAP    = 6;
endpackage

// File: rtl/pma_sync.sv
// Module: multi-flop synchroniser for a bundle of independent level flags.
// Assumes each bit is a slow level signal, so no bits are required to move
// together. Reset clears all stages.
module pma_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: capture the asynchronous flags.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_in;
                end
            end else begin : g_next
                // Purpose: settle the flags through one more flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/pma_auto_filter.sv
// Module: computes the automatic interface choice from the synchronised
// detect flags and the select bit, and accepts a new choice only after it
// has been computed on `settle` consecutive edges (0 is taken as 1).
// Assumes the flags are already synchronous to clk.
module pma_auto_filter
    import pma_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       ana_flags,
    input  logic             dig_flag,
    input  logic             sel,
    input  logic [CNT_W-1:0] settle,
    output pmode_e           auto_next,
    output pmode_e           auto_q
);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] RUN_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic             ana_seen;
    pmode_e           raw_choice;
    pmode_e           prev_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_nxt;
    logic [CNT_W-1:0] thresh;

    assign ana_seen = |ana_flags;

    // Purpose: instantaneous choice from detection, tie broken by sel.
    always_comb begin
        unique case ({ana_seen, dig_flag})
            2'b00:   raw_choice = MODE_SEEK;
            2'b10:   raw_choice = MODE_ANA;
            2'b01:   raw_choice = MODE_DIG;
            default: raw_choice = sel ? MODE_DIG : MODE_ANA;
        endcase
    end

    // Purpose: length of the current run of equal choices, saturating.
    always_comb begin
        if (raw_choice != prev_q)  run_nxt = RUN_ONE;
        else if (run_q == RUN_MAX) run_nxt = run_q;
        else                       run_nxt = run_q + RUN_ONE;
        thresh    = (settle == '0) ? RUN_ONE : settle;
        auto_next = (run_nxt >= thresh) ? raw_choice : auto_q;
    end

    // Purpose: hold the previous choice, run length and accepted choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= MODE_SEEK;
            run_q  <= '0;
            auto_q <= MODE_SEEK;
        end else begin
            prev_q <= raw_choice;
            run_q  <= run_nxt;
            auto_q <= auto_next;
        end
    end

    // R8: an accepted choice only ever changes to the choice seen at that edge.
    assert_accept_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(auto_q) |-> auto_q == $past(raw_choice));

    // R8: the run counter never wraps back to zero once running.
    assert_no_run_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_q) != '0) |-> run_q != '0);
endmodule

// File: rtl/pma_mode_sel.sv
// Module: applies the priority order (shutdown, then override, then the
// filtered automatic choice) and registers the resulting mode.
// Assumes the control bits are synchronous to clk.
module pma_mode_sel
    import pma_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   shutdown,
    input  logic   ovr_en,
    input  logic   sel,
    input  pmode_e auto_next,
    output pmode_e mode_q
);
    pmode_e mode_nxt;

    // Purpose: pick the next mode by priority.
    always_comb begin
        if (shutdown)    mode_nxt = MODE_OFF;
        else if (ovr_en) mode_nxt = sel ? MODE_DIG : MODE_ANA;
        else             mode_nxt = auto_next;
    end

    // Purpose: hold the current mode; reset parks it in seek.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_SEEK;
        else        mode_q <= mode_nxt;
    end

    // R2: shutdown forces the off mode on the next cycle.
    assert_shutdown_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> mode_q == MODE_OFF);

    // R3: override with select 0 forces analog.
    assert_ovr_analog_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!shutdown && ovr_en && !sel) |=> mode_q == MODE_ANA);

    // R3: override with select 1 forces digital.
    assert_ovr_digital_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!shutdown && ovr_en && sel) |=> mode_q == MODE_DIG);

    // R12: only the four legal codes appear.
    assert_legal_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q inside {MODE_OFF, MODE_SEEK, MODE_ANA, MODE_DIG});
endmodule

// File: rtl/pma_pwr_decode.sv
// Module: decodes the registered mode into one enable per circuit group and
// the sync indication. Purely combinational from the mode register.
module pma_pwr_decode
    import pma_pkg::*;
(
    input  pmode_e          mode,
    output logic [EN_W-1:0] en,
    output logic            sync_seen
);
    // Purpose: per-mode set of powered circuit groups.
    always_comb begin
        en = '0;
        unique case (mode)
            MODE_SEEK: begin
                en[EN_ANA_ACT] = 1'b1;
                en[EN_DIG_CLK] = 1'b1;
                en[EN_SOG]     = 1'b1;
                en[EN_BGAP]    = 1'b1;
            end
            MODE_ANA: begin
                en[EN_ANA_DP]  = 1'b1;
                en[EN_DIG_CLK] = 1'b1;
                en[EN_SOG]     = 1'b1;
                en[EN_OUTDRV]  = 1'b1;
                en[EN_BGAP]    = 1'b1;
            end
            MODE_DIG: begin
                en[EN_DIG_DP]  = 1'b1;
                en[EN_ANA_ACT] = 1'b1;
                en[EN_SOG]     = 1'b1;
                en[EN_OUTDRV]  = 1'b1;
                en[EN_BGAP]    = 1'b1;
            end
            default: en = '0;
        endcase
        sync_seen = (mode == MODE_ANA) || (mode == MODE_DIG);
    end
endmodule

// File: rtl/pwr_mode_arbiter.sv
// Module: top of the dual-interface power mode arbiter. Synchronises the
// detect flags, filters the automatic choice, applies the priority order
// and decodes the enables. Assumes control bits come from a register bank
// clocked by clk.
module pwr_mode_arbiter
    import pma_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       ana_act,
    input  logic             dig_clk_seen,
    input  logic             shutdown,
    input  logic             ovr_en,
    input  logic             if_sel,
    input  logic [CNT_W-1:0] settle,
    output logic [2:0]       mode_code,
    output logic [6:0]       pwr_en,
    output logic             sync_seen,
    output logic [7:0]       status
);
    localparam int FLAG_W = 4;

    logic [FLAG_W-1:0] flags_s;
    pmode_e            auto_next;
    pmode_e            auto_q;
    pmode_e            mode_q;
    logic [EN_W-1:0]   en_w;
    logic              sync_w;

    pma_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({dig_clk_seen, ana_act}),
        .d_out (flags_s)
    );

    pma_auto_filter #(.CNT_W(CNT_W)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .ana_flags (flags_s[2:0]),
        .dig_flag  (flags_s[3]),
        .sel       (if_sel),
        .settle    (settle),
        .auto_next (auto_next),
        .auto_q    (auto_q)
    );

    pma_mode_sel u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .shutdown  (shutdown),
        .ovr_en    (ovr_en),
        .sel       (if_sel),
        .auto_next (auto_next),
        .mode_q    (mode_q)
    );

    pma_pwr_decode u_dec (
        .mode      (mode_q),
        .en        (en_w),
        .sync_seen (sync_w)
    );

    assign mode_code = mode_q;
    assign pwr_en    = en_w;
    assign sync_seen = sync_w;
    assign status    = {flags_s[2:0], flags_s[3], sync_w, mode_q};

    // R9: the two datapaths are never both enabled.
    assert_one_datapath_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_en[EN_ANA_DP] && pwr_en[EN_DIG_DP]));

    // R9: the off mode leaves every group unpowered.
    assert_off_all_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_OFF) |-> pwr_en == '0);

    // R10: sync indication tracks an active interface.
    assert_sync_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_seen == (mode_q == MODE_ANA || mode_q == MODE_DIG));

    // R8: with no override or shutdown, mode follows the accepted choice.
    assert_auto_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!shutdown && !ovr_en) |=> mode_q == auto_q);
endmodule

// File: tb/pwr_mode_arbiter_tb.sv
module pwr_mode_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int SYNC       = 2;
    localparam int RUN_MAX    = (1 << CNT_W) - 1;
    localparam int WATCHDOG   = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       ana_act = '0;
    logic             dig_clk_seen = 1'b0;
    logic             shutdown = 1'b0;
    logic             ovr_en = 1'b0;
    logic             if_sel = 1'b0;
    logic [CNT_W-1:0] settle = 8'd1;
    logic [2:0]       mode_code;
    logic [6:0]       pwr_en;
    logic             sync_seen;
    logic [7:0]       status;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    started = 0;
    string cur_req = "R1";

    // reference model state
    logic [3:0] m_sync [SYNC];
    int         m_prev = 1;
    int         m_run = 0;
    int         m_acc = 1;
    int         m_mode = 1;

    pwr_mode_arbiter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ana_act(ana_act), .dig_clk_seen(dig_clk_seen),
        .shutdown(shutdown), .ovr_en(ovr_en), .if_sel(if_sel), .settle(settle),
        .mode_code(mode_code), .pwr_en(pwr_en), .sync_seen(sync_seen), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [6:0] exp_en(int m);
        case (m)
            1: return 7'b1011100;
            2: return 7'b1111001;
            3: return 7'b1110110;
            default: return 7'b0000000;
        endcase
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        int raw;
        int thr;
        logic da;
        logic dd;
        started = 1;
        cycles++;
        if (!rst_n) begin
            for (int i = 0; i < SYNC; i++) m_sync[i] = '0;
            m_prev = 1; m_run = 0; m_acc = 1; m_mode = 1;
        end else begin
            da = |m_sync[SYNC-1][2:0];
            dd = m_sync[SYNC-1][3];
            if (!da && !dd)     raw = 1;
            else if (da && !dd) raw = 2;
            else if (!da && dd) raw = 3;
            else                raw = if_sel ? 3 : 2;
            if (raw == m_prev) begin
                if (m_run < RUN_MAX) m_run++;
            end else m_run = 1;
            m_prev = raw;
            thr = (settle == 0) ? 1 : int'(settle);
            if (m_run >= thr) m_acc = raw;
            if (shutdown)    m_mode = 0;
            else if (ovr_en) m_mode = if_sel ? 3 : 2;
            else             m_mode = m_acc;
            for (int i = SYNC-1; i > 0; i--) m_sync[i] = m_sync[i-1];
            m_sync[0] = {dig_clk_seen, ana_act};
        end
    end

    // compare every output on the falling edge
    always @(negedge clk) begin
        logic [7:0] st;
        if (started) begin
            st = {m_sync[SYNC-1][2:0], m_sync[SYNC-1][3],
                  (m_mode == 2 || m_mode == 3) ? 1'b1 : 1'b0, 3'(m_mode)};
            n_vec++;
            if (mode_code !== 3'(m_mode) || pwr_en !== exp_en(m_mode) ||
                sync_seen !== st[3] || status !== st) begin
                n_bad++;
                $display("FAIL %s (R12/R9/R10/R11) t=%0t mode %0d exp %0d en %b exp %b sync %b exp %b status %h exp %h",
                         cur_req, $time, mode_code, m_mode, pwr_en, exp_en(m_mode),
                         sync_seen, st[3], status, st);
            end
        end
        if (cycles > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(logic [2:0] a, logic d, int n);
        @(negedge clk);
        ana_act = a; dig_clk_seen = d;
        run(n);
    endtask

    initial begin
        cur_req = "R1";
        run(4);
        rst_n = 1'b1;
        run(6);

        cur_req = "R4"; settle = 8'd1;
        drive(3'b001, 0, 5); drive(3'b000, 0, 5);
        drive(3'b010, 0, 5); drive(3'b100, 0, 5);
        drive(3'b110, 0, 5);
        cur_req = "R5"; drive(3'b000, 0, 6);
        cur_req = "R6"; drive(3'b000, 1, 6); drive(3'b011, 0, 6);
        cur_req = "R7"; if_sel = 1'b0; drive(3'b101, 1, 6);
        @(negedge clk); if_sel = 1'b1; run(6);
        drive(3'b111, 1, 6);

        cur_req = "R8"; settle = 8'd5; if_sel = 1'b0;
        drive(3'b000, 0, 8);
        drive(3'b010, 0, 3); drive(3'b000, 0, 8);
        drive(3'b010, 0, 10);
        drive(3'b000, 1, 4); drive(3'b010, 0, 8);
        settle = 8'd0;
        drive(3'b000, 0, 5); drive(3'b000, 1, 5);

        cur_req = "R3"; settle = 8'd2;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            ovr_en = 1'b1; if_sel = 1'(i / 10);
            ana_act = 3'($urandom); dig_clk_seen = 1'($urandom);
        end
        cur_req = "R2";
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            shutdown = 1'b1; ovr_en = 1'($urandom); if_sel = 1'($urandom);
            ana_act = 3'($urandom); dig_clk_seen = 1'($urandom);
        end
        @(negedge clk); shutdown = 1'b0; ovr_en = 1'b0;
        run(8);

        cur_req = "R12"; settle = 8'd3;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) begin
                ana_act = 3'($urandom); dig_clk_seen = 1'($urandom);
            end
            if ($urandom_range(0, 15) == 0) if_sel = ~if_sel;
            ovr_en   = ($urandom_range(0, 19) == 0);
            shutdown = ($urandom_range(0, 29) == 0);
        end

        cur_req = "R1";
        @(negedge clk); rst_n = 1'b0; ana_act = '0; dig_clk_seen = 1'b0;
        shutdown = 1'b0; ovr_en = 1'b0;
        run(3); rst_n = 1'b1; run(4);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule